// File: doc/BRIEF.md
# Effective Address Decoder and Generator

This block sits in the operand path of a 16-bit processor core. From the leading byte of a general-format instruction it works out the addressing mode, the operand size and the number of bytes that the address field takes. It then forms the operand address from the register file and the address-field bytes. For the two auto-adjust modes it also produces the new base-register value that the register file should take. It works on the address only. The operation that uses the operand is handled elsewhere.

Each request enters on a valid/ready input. The block reads one register through a combinational port in the same cycle. The decoded result is registered and leaves on a valid/ready output. A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output slot is empty or is being emptied in that cycle, so a stalled output stops the input. While `out_valid` is high and `out_ready` is low, every output field holds its value. The caller must hold `in_first`, `in_ext`, `in_tail` and `in_rmw_write` steady while `in_valid` is high. It must return `rf_rd_data` for `rf_rd_idx` in the same cycle.

Top module: `ea_unit`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: A request accepted on a clock edge shows up on the output right after that edge. It stays unchanged until `out_valid && out_ready`. `in_ready` equals `!out_valid || out_ready`.
- R3: Mode codes are 0 register, 1 pre-decrement, 2 post-increment, 3 indirect, 4 register+8-bit displacement, 5 register+16-bit displacement, 6 immediate and 7 absolute. Leading bytes 0xA0–0xDF give modes 0–3 by their upper nibble (A, B, C, D), with address-field length 1. In every register-based mode (0xA0–0xFF), bits 2:0 give `out_reg` and bit 3 gives `out_word` (1 = word, 0 = byte).
- R4: 0xE0–0xEF give address = register + sign-extended byte 1, with length 2. 0xF0–0xFF give address = register + {byte 1, byte 2}, with length 3. Both wrap modulo 2^16. Byte 1 is `in_ext[15:8]` and byte 2 is `in_ext[7:0]`.
- R5: 0x04 gives a byte immediate, with `out_imm` = zero-extended byte 1 and length 2. 0x0C gives a word immediate, with `out_imm` = {byte 1, byte 2} and length 3. Both have `out_addr` = 0 and `out_reg` = 0.
- R6: 0x15 gives a byte absolute and 0x1D a word absolute. Both have `out_addr` = {byte 1, byte 2}, length 3 and `out_reg` = 0.
- R7: Pre-decrement gives address = register − size (1 or 2) modulo 2^16, with `out_wb_en` = 1 and `out_wb_data` equal to that address.
- R8: Post-increment gives address = register and `out_wb_data` = register + size modulo 2^16. `out_wb_en` is 1 only when `in_rmw_write` is 0.
- R9: Register-direct gives `out_addr` = 0 and indirect gives address = register. Neither mode, nor the displacement, immediate or absolute modes, raises `out_wb_en`.
- R10: Any other leading byte sets `out_illegal`. All other output fields are then 0 (mode, size, register, both lengths, address, immediate and write-back).
- R11: For legal bytes, `out_insn_len` = address-field length + 1 + `in_tail`, where `in_tail` (0, 1 or 2) counts the immediate data bytes that follow the opcode byte.
- R12: Fields not used by a mode are 0: `out_imm` outside mode 6 and `out_wb_data` outside modes 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_first | input | 8 | Leading byte of the instruction |
| in_ext | input | 16 | The two bytes after the leading byte, byte 1 in the upper half |
| in_tail | input | 2 | Immediate data bytes after the opcode byte (0 to 2) |
| in_rmw_write | input | 1 | Request is the write-back access of a read-modify-write |
| rf_rd_idx | output | 3 | Register number to read |
| rf_rd_data | input | AW | Contents of that register, same cycle |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_mode | output | 3 | Addressing mode code |
| out_word | output | 1 | Operand size is word |
| out_reg | output | 3 | Base register, and write-back target |
| out_ea_len | output | 2 | Address-field length in bytes |
| out_insn_len | output | 3 | Total instruction length in bytes |
| out_illegal | output | 1 | Leading byte is not a known mode |
| out_addr | output | AW | Operand address |
| out_imm | output | AW | Immediate operand value |
| out_wb_en | output | 1 | Base register is to be written |
| out_wb_data | output | AW | New base register value |

## Verification
The assertions assume that the caller keeps `in_tail` within 0 to 2. The length bound is only meaningful under that rule. They also assume that the request fields do not change while `in_valid` is high and the output is stalled. The bench produces its stimulus within these rules: tails come from the set {0, 1, 2}, and inputs change only at the falling edge. The register file in the bench is a fixed set of values chosen to reach the wrap points. Write-backs are checked on the port and are not written back into it, so every request in flight sees the same register contents as the reference model.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam int BYTE_W = 8;
  localparam int RIDX_W = 3;
  localparam int MODE_W = 3;
  localparam int ELEN_W = 2;
  localparam int ILEN_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_REG     = 3'd0,
    MD_PREDEC  = 3'd1,
    MD_POSTINC = 3'd2,
    MD_IND     = 3'd3,
    MD_DISP8   = 3'd4,
    MD_DISP16  = 3'd5,
    MD_IMM     = 3'd6,
    MD_ABS     = 3'd7
  } ea_mode_e;

  typedef struct packed {
    ea_mode_e              mode;
    logic                  word;
    logic [RIDX_W-1:0]     rsel;
    logic [ELEN_W-1:0]     ea_len;
    logic                  illegal;
  } ea_dec_t;

  // leading-byte codes for the non-register modes
  localparam logic [BYTE_W-1:0] LB_IMM_B = 8'h04;
  localparam logic [BYTE_W-1:0] LB_IMM_W = 8'h0C;
  localparam logic [BYTE_W-1:0] LB_ABS_B = 8'h15;
  localparam logic [BYTE_W-1:0] LB_ABS_W = 8'h1D;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
(
  input  logic [BYTE_W-1:0] lead,
  output ea_dec_t           dec
);

  logic [3:0] hi_nib;
  assign hi_nib = lead[7:4];

  always_comb begin
    dec         = '0;
    dec.mode    = MD_REG;
    dec.word    = lead[3];
    dec.rsel    = lead[RIDX_W-1:0];
    dec.illegal = 1'b0;
    unique case (hi_nib)
      4'hA: begin dec.mode = MD_REG;     dec.ea_len = 2'd1; end
      4'hB: begin dec.mode = MD_PREDEC;  dec.ea_len = 2'd1; end
      4'hC: begin dec.mode = MD_POSTINC; dec.ea_len = 2'd1; end
      4'hD: begin dec.mode = MD_IND;     dec.ea_len = 2'd1; end
      4'hE: begin dec.mode = MD_DISP8;   dec.ea_len = 2'd2; end
      4'hF: begin dec.mode = MD_DISP16;  dec.ea_len = 2'd3; end
      default: begin
        dec.rsel = '0;
        if (lead == LB_IMM_B) begin
          dec.mode = MD_IMM; dec.word = 1'b0; dec.ea_len = 2'd2;
        end else if (lead == LB_IMM_W) begin
          dec.mode = MD_IMM; dec.word = 1'b1; dec.ea_len = 2'd3;
        end else if (lead == LB_ABS_B) begin
          dec.mode = MD_ABS; dec.word = 1'b0; dec.ea_len = 2'd3;
        end else if (lead == LB_ABS_W) begin
          dec.mode = MD_ABS; dec.word = 1'b1; dec.ea_len = 2'd3;
        end else begin
          dec.mode    = MD_REG;
          dec.word    = 1'b0;
          dec.ea_len  = '0;
          dec.illegal = 1'b1;
        end
      end
    endcase
  end

endmodule

// File: rtl/ea_addr_gen.sv
module ea_addr_gen
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  ea_dec_t              dec,
  input  logic [2*BYTE_W-1:0]  ext,
  input  logic [AW-1:0]        base,
  input  logic                 rmw_write,
  output logic [AW-1:0]        addr,
  output logic [AW-1:0]        imm,
  output logic                 wb_en,
  output logic [AW-1:0]        wb_data
);

  localparam int EXT_W = 2 * BYTE_W;

  logic [AW-1:0] step;
  logic [AW-1:0] disp_s;
  logic [AW-1:0] disp_l;
  logic [AW-1:0] absval;
  logic [AW-1:0] dec_val;
  logic [AW-1:0] inc_val;
  logic signed [BYTE_W-1:0] ext_hi_s;
  logic signed [EXT_W-1:0]  ext_s;

  assign ext_hi_s = ext[EXT_W-1 -: BYTE_W];
  assign ext_s    = ext;
  assign step     = dec.word ? AW'(2) : AW'(1);
  assign disp_s   = AW'(ext_hi_s);
  assign disp_l   = AW'(ext_s);
  assign absval   = AW'(ext);
  assign dec_val  = base - step;
  assign inc_val  = base + step;

  always_comb begin
    addr    = '0;
    imm     = '0;
    wb_en   = 1'b0;
    wb_data = '0;
    if (!dec.illegal) begin
      unique case (dec.mode)
        MD_REG:     addr = '0;
        MD_PREDEC: begin
          addr    = dec_val;
          wb_en   = 1'b1;
          wb_data = dec_val;
        end
        MD_POSTINC: begin
          addr    = base;
          wb_en   = !rmw_write;
          wb_data = inc_val;
        end
        MD_IND:     addr = base;
        MD_DISP8:   addr = base + disp_s;
        MD_DISP16:  addr = base + disp_l;
        MD_IMM:     imm  = dec.word ? absval : AW'(ext[EXT_W-1 -: BYTE_W]);
        MD_ABS:     addr = absval;
        default:    addr = '0;
      endcase
    end
  end

endmodule

// File: rtl/ea_out_stage.sv
module ea_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);

  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_valid <= 1'b0;
      dn_data  <= '0;
    end else if (up_ready) begin
      dn_valid <= up_valid;
      if (up_valid) dn_data <= up_data;
    end
  end

endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_first,
  input  logic [15:0]       in_ext,
  input  logic [1:0]        in_tail,
  input  logic              in_rmw_write,
  output logic [2:0]        rf_rd_idx,
  input  logic [AW-1:0]     rf_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_mode,
  output logic              out_word,
  output logic [2:0]        out_reg,
  output logic [1:0]        out_ea_len,
  output logic [2:0]        out_insn_len,
  output logic              out_illegal,
  output logic [AW-1:0]     out_addr,
  output logic [AW-1:0]     out_imm,
  output logic              out_wb_en,
  output logic [AW-1:0]     out_wb_data
);

  localparam int PW = MODE_W + 1 + RIDX_W + ELEN_W + ILEN_W + 1 + 3*AW + 1;

  ea_dec_t       dec;
  logic [AW-1:0] g_addr, g_imm, g_wbd;
  logic          g_wbe;
  logic [ILEN_W-1:0] ilen;
  logic [PW-1:0] pay_in, pay_out;

  ea_mode_decode u_dec (
    .lead (in_first),
    .dec  (dec)
  );

  assign rf_rd_idx = in_first[RIDX_W-1:0];

  ea_addr_gen #(.AW(AW)) u_gen (
    .dec       (dec),
    .ext       (in_ext),
    .base      (rf_rd_data),
    .rmw_write (in_rmw_write),
    .addr      (g_addr),
    .imm       (g_imm),
    .wb_en     (g_wbe),
    .wb_data   (g_wbd)
  );

  assign ilen = dec.illegal ? '0
              : ILEN_W'(dec.ea_len) + ILEN_W'(1) + ILEN_W'(in_tail);

  assign pay_in = {dec.mode, dec.word, dec.rsel, dec.ea_len, ilen,
                   dec.illegal, g_addr, g_imm, g_wbe, g_wbd};

  ea_out_stage #(.W(PW)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (pay_in),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (pay_out)
  );

  assign {out_mode, out_word, out_reg, out_ea_len, out_insn_len,
          out_illegal, out_addr, out_imm, out_wb_en, out_wb_data} = pay_out;

endmodule

// File: rtl/ea_unit_checker.sv
module ea_unit_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [2:0]    out_mode,
  input logic [1:0]    out_ea_len,
  input logic [2:0]    out_insn_len,
  input logic          out_illegal,
  input logic [AW-1:0] out_addr,
  input logic          out_wb_en,
  input logic [AW-1:0] out_wb_data
);

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
      && $stable(out_mode) && $stable(out_wb_data)));

  a_r10_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> (!out_wb_en && out_insn_len == 3'd0
      && out_addr == '0));

  a_r9_wb_only_adjust: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wb_en) |-> (out_mode == 3'd1 || out_mode == 3'd2));

  a_r7_predec_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && out_mode == 3'd1)
      |-> (out_wb_en && out_wb_data == out_addr));

  a_r4_disp_len: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal && out_mode == 3'd4) |-> out_ea_len == 2'd2);

  a_r11_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_illegal) |-> (out_insn_len > {1'b0, out_ea_len}
      && out_insn_len <= {1'b0, out_ea_len} + 3'd3));

endmodule

bind ea_unit ea_unit_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_mode     (out_mode),
  .out_ea_len   (out_ea_len),
  .out_insn_len (out_insn_len),
  .out_illegal  (out_illegal),
  .out_addr     (out_addr),
  .out_wb_en    (out_wb_en),
  .out_wb_data  (out_wb_data)
);

// File: tb/ea_unit_test.sv
`timescale 1ns/1ps
module ea_unit_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 0, in_ready, in_rmw_write = 0, out_valid, out_ready = 0;
  logic [7:0]  in_first = 0;
  logic [15:0] in_ext = 0;
  logic [1:0]  in_tail = 0;
  logic [2:0]  rf_rd_idx, out_mode, out_reg, out_insn_len;
  logic [15:0] rf_rd_data, out_addr, out_imm, out_wb_data;
  logic        out_word, out_illegal, out_wb_en;
  logic [1:0]  out_ea_len;

  logic [15:0] rf [8];
  assign rf_rd_data = rf[rf_rd_idx];

  ea_unit uut (.*);

  typedef struct {
    int mode, word, rg, el, il, ill, addr, imm, wb, wbd;
  } exp_t;
  exp_t q[$];

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  function automatic exp_t model(int f, int x, int t, int rmw);
    exp_t e = '{default: 0};
    int hi = f >> 4;
    int base, step, d8;
    if (hi >= 10) begin
      e.mode = hi - 10;
      e.rg = f & 7;
      e.word = (f >> 3) & 1;
      e.el = (hi <= 13) ? 1 : (hi == 14 ? 2 : 3);
      base = rf[e.rg];
      step = e.word ? 2 : 1;
      d8 = (x >> 8) & 255;
      if (d8 > 127) d8 = d8 - 256;
      if (e.mode == 1) begin
        e.addr = (base - step) & 16'hFFFF; e.wb = 1; e.wbd = e.addr;
      end else if (e.mode == 2) begin
        e.addr = base; e.wb = rmw ? 0 : 1; e.wbd = (base + step) & 16'hFFFF;
      end else if (e.mode == 3) e.addr = base;
      else if (e.mode == 4) e.addr = (base + d8) & 16'hFFFF;
      else if (e.mode == 5) e.addr = (base + x) & 16'hFFFF;
    end else if (f == 8'h04 || f == 8'h0C) begin
      e.mode = 6; e.word = (f == 8'h0C);
      e.el = e.word ? 3 : 2;
      e.imm = e.word ? x : ((x >> 8) & 255);
    end else if (f == 8'h15 || f == 8'h1D) begin
      e.mode = 7; e.word = (f == 8'h1D); e.el = 3; e.addr = x;
    end else begin
      e.ill = 1;
      return e;
    end
    e.il = e.el + 1 + t;
    return e;
  endfunction

  function automatic void chk(string tag, string nm, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endfunction

  function automatic string tag_of(exp_t e);
    if (e.ill) return "R10";
    case (e.mode)
      1: return "R7";
      2: return "R8";
      4, 5: return "R4";
      6: return "R5";
      7: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic compare();
    exp_t e;
    string tg;
    chk("R2", "out_valid", int'(out_valid), int'(q.size() != 0));
    if (out_valid && q.size() != 0) begin
      e = q[0];
      tg = tag_of(e);
      chk("R3", "out_mode", int'(out_mode), e.mode);
      chk("R3", "out_word", int'(out_word), e.word);
      chk("R3", "out_reg", int'(out_reg), e.rg);
      chk(tg, "out_ea_len", int'(out_ea_len), e.el);
      chk("R11", "out_insn_len", int'(out_insn_len), e.il);
      chk("R10", "out_illegal", int'(out_illegal), e.ill);
      chk(tg, "out_addr", int'(out_addr), e.addr);
      chk("R12", "out_imm", int'(out_imm), e.imm);
      chk(tg, "out_wb_en", int'(out_wb_en), e.wb);
      chk("R12", "out_wb_data", int'(out_wb_data), e.wbd);
    end
  endtask

  task automatic step(input logic v, input int f, input int x, input int t,
                      input logic rmw, input logic ordy);
    @(negedge clk);
    compare();
    in_valid = v; in_first = 8'(f); in_ext = 16'(x);
    in_tail = 2'(t); in_rmw_write = rmw; out_ready = ordy;
    #1;
    chk("R2", "in_ready", int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && out_ready && q.size() != 0) void'(q.pop_front());
    if (in_valid && in_ready) q.push_back(model(f, x, t, int'(rmw)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rf[0] = 16'h0000; rf[1] = 16'h0001; rf[2] = 16'hFFFF; rf[3] = 16'hFFFE;
    rf[4] = 16'h7FFF; rf[5] = 16'h8000; rf[6] = 16'h1234; rf[7] = 16'hFE80;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    chk("R1", "in_ready after reset", int'(in_ready), 1);

    // R3/R9 register direct and indirect
    step(1, 8'hA3, 16'h0000, 0, 0, 1);
    step(1, 8'hAB, 16'h0000, 1, 0, 1);
    step(1, 8'hD6, 16'h0000, 2, 0, 1);
    // R7 pre-decrement, byte and word, wrap through zero
    step(1, 8'hB2, 16'h0000, 0, 0, 1);
    step(1, 8'hB8, 16'h0000, 0, 0, 1);
    // R8 post-increment, wrap at top, and suppressed on write-back access
    step(1, 8'hC1, 16'h0000, 0, 0, 1);
    step(1, 8'hCA, 16'h0000, 0, 0, 1);
    step(1, 8'hCA, 16'h0000, 0, 1, 1);
    // R4 displacements: negative byte, positive byte, 16-bit wrap
    step(1, 8'hE4, 16'h8000, 0, 0, 1);
    step(1, 8'hED, 16'h7F00, 1, 0, 1);
    step(1, 8'hF7, 16'h0200, 0, 0, 1);
    step(1, 8'hFD, 16'h8000, 2, 0, 1);
    // R5 immediates, R6 absolutes
    step(1, 8'h04, 16'hAB77, 1, 0, 1);
    step(1, 8'h0C, 16'hBEEF, 2, 0, 1);
    step(1, 8'h15, 16'hFF11, 0, 0, 1);
    step(1, 8'h1D, 16'h0042, 2, 0, 1);
    // R10 illegal leading bytes
    step(1, 8'h00, 16'h1234, 1, 0, 1);
    step(1, 8'h05, 16'h1234, 0, 0, 1);
    step(1, 8'h1C, 16'h1234, 2, 0, 1);
    step(1, 8'h9F, 16'hFFFF, 0, 1, 1);
    // R2 back-pressure: stall output, input must wait, result must hold
    step(1, 8'hB9, 16'h0000, 0, 0, 0);
    step(1, 8'hC6, 16'h0000, 0, 0, 0);
    step(1, 8'hC6, 16'h0000, 0, 0, 0);
    step(1, 8'hC6, 16'h0000, 0, 0, 1);
    step(0, 8'h00, 16'h0000, 0, 0, 1);
    step(0, 8'h00, 16'h0000, 0, 0, 1);

    for (int i = 0; i < 600; i++) begin
      step(logic'($urandom % 4 != 0), int'($urandom % 256), int'($urandom % 65536),
           int'($urandom % 3), logic'($urandom % 2), logic'($urandom % 3 != 0));
    end
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    @(negedge clk);
    compare();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule